// File: doc/BRIEF.md
# Serial In-Band Flow Controller

This block carries out character-based (XON/XOFF) software flow control for one serial port. It watches every byte that the deserializer delivers. When a configured stop character arrives it holds the local transmitter, and when a matching resume character arrives it releases it. Matched flow characters are removed from the receive stream, and each one raises an interrupt. Every other byte is passed on to the receive data path.

On the transmit side the block watches the local receive-buffer fill level against a high threshold and a low threshold. When the level crosses a threshold it asks the transmitter to insert a stop or resume character.

Two character pairs can be programmed. A 4-bit mode field selects, for each direction, whether pair one, pair two or both pairs in sequence are used. An option lets any received byte end a hold.

Top module: `xonxoff_flow_ctl`

## Requirements
- R1: With receive mode `cfg_flow[1:0]`=10, a byte equal to `cfg_xoff1` sets `tx_hold`, and a byte equal to `cfg_xon1` clears it. Each change is visible one cycle after the byte is presented. Bytes from pair two are not recognised in this mode.
- R2: With receive mode 01, `cfg_xoff2` sets `tx_hold` and `cfg_xon2` clears it. Bytes from pair one are forwarded as data and do not change `tx_hold`.
- R3: With receive mode 11, stop is recognised only as `cfg_xoff1` followed at once by `cfg_xoff2`, and resume only as `cfg_xon1` followed at once by `cfg_xon2`. The first character of a pair is consumed. If the byte after it does not complete the pair, the pending first character is dropped, that byte is forwarded, and matching starts over.
- R4: A byte that is not consumed as a flow character appears on `rx_out_byte`, with `rx_out_valid` high for one cycle, one cycle after it is presented. A consumed byte never appears there.
- R5: When `cfg_any_resume`=1, any received byte that does not complete a stop clears `tx_hold`.
- R6: Receive mode 00 clears `tx_hold` within one cycle and recognises no character; every byte is forwarded.
- R7: A completed stop or resume sets `irq` one cycle later, and `irq_code` then reads 0x10. `irq` stays set until `irq_ack`. While `irq` is low, `irq_code` reads 0.
- R8: When `rx_level` > `lvl_hi` and no stop has been sent, `ins_req` rises one cycle later. `ins_char` is `cfg_xoff2` in transmit mode `cfg_flow[3:2]`=01, and `cfg_xoff1` in modes 10 and 11.
- R9: After a stop has been sent, `rx_level` < `lvl_lo` raises a resume request one cycle later. `ins_char` is `cfg_xon2` in mode 01, and `cfg_xon1` otherwise.
- R10: `ins_req` and `ins_char` hold until a cycle with `ins_ack` high. In transmit mode 11 the first acknowledge changes `ins_char` to the pair-two character, and the second acknowledge ends the request. `xoff_sent` is set when a stop request completes and cleared when a resume request completes.
- R11: Transmit mode 00 raises no request, drops any pending request and clears `xoff_sent` within one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_xon1 | input | 8 | Resume character, pair one |
| cfg_xoff1 | input | 8 | Stop character, pair one |
| cfg_xon2 | input | 8 | Resume character, pair two |
| cfg_xoff2 | input | 8 | Stop character, pair two |
| cfg_flow | input | 4 | [3:2] transmit mode, [1:0] receive mode |
| cfg_any_resume | input | 1 | Any received byte ends a hold |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_out_valid | output | 1 | Forwarded byte strobe |
| rx_out_byte | output | 8 | Forwarded byte |
| tx_hold | output | 1 | Transmitter paused by the remote side |
| rx_level | input | 8 | Local receive-buffer fill level |
| lvl_hi | input | 8 | Level above which a stop is sent |
| lvl_lo | input | 8 | Level below which a resume is sent |
| ins_req | output | 1 | Flow character insertion request |
| ins_char | output | 8 | Character to insert |
| ins_ack | input | 1 | Transmitter takes `ins_char` |
| xoff_sent | output | 1 | A stop has been sent locally |
| irq | output | 1 | Flow-character interrupt pending |
| irq_code | output | 6 | Pending cause code |
| irq_ack | input | 1 | Clears `irq` |

## Verification
Every result is one register stage from its cause. A received byte changes `tx_hold`, `irq` and the forwarded-byte strobe at the next edge. A level crossing raises `ins_req` at the next edge, and an acknowledge advances or ends the request at the edge where it is sampled. The bench drives each stimulus for exactly one cycle starting at a falling edge and reads the outputs at the following falling edge, which is half a period after the edge that registered them. Tests for held-request stability wait several cycles without an acknowledge and then check again.

// File: rtl/xonxoff_flow_ctl.sv
module xonxoff_flow_ctl #(
  parameter int CW = 8,
  parameter int LW = 8,
  parameter logic [5:0] IRQ_CODE = 6'h10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_xon1,
  input  logic [CW-1:0] cfg_xoff1,
  input  logic [CW-1:0] cfg_xon2,
  input  logic [CW-1:0] cfg_xoff2,
  input  logic [3:0]    cfg_flow,
  input  logic          cfg_any_resume,
  input  logic          rx_valid,
  input  logic [CW-1:0] rx_byte,
  output logic          rx_out_valid,
  output logic [CW-1:0] rx_out_byte,
  output logic          tx_hold,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] lvl_hi,
  input  logic [LW-1:0] lvl_lo,
  output logic          ins_req,
  output logic [CW-1:0] ins_char,
  input  logic          ins_ack,
  output logic          xoff_sent,
  output logic          irq,
  output logic [5:0]    irq_code,
  input  logic          irq_ack
);
  localparam logic [1:0] M_OFF = 2'b00, M_P2 = 2'b01, M_P1 = 2'b10, M_BOTH = 2'b11;

  wire [1:0] rmode = cfg_flow[1:0];
  wire [1:0] tmode = cfg_flow[3:2];

  wire is_on1  = rx_byte == cfg_xon1;
  wire is_off1 = rx_byte == cfg_xoff1;
  wire is_on2  = rx_byte == cfg_xon2;
  wire is_off2 = rx_byte == cfg_xoff2;

  logic pend_on, pend_off;
  logic on_evt, off_evt, eat, nxt_pon, nxt_poff;

  always_comb begin
    on_evt = 1'b0; off_evt = 1'b0; eat = 1'b0; nxt_pon = 1'b0; nxt_poff = 1'b0;
    if (rx_valid) begin
      case (rmode)
        M_P1: begin on_evt = is_on1; off_evt = is_off1; eat = is_on1 | is_off1; end
        M_P2: begin on_evt = is_on2; off_evt = is_off2; eat = is_on2 | is_off2; end
        M_BOTH: begin
          if (pend_on && is_on2)        begin on_evt = 1'b1; eat = 1'b1; end
          else if (pend_off && is_off2) begin off_evt = 1'b1; eat = 1'b1; end
          else if (is_on1)              begin nxt_pon = 1'b1; eat = 1'b1; end
          else if (is_off1)             begin nxt_poff = 1'b1; eat = 1'b1; end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_on <= 1'b0; pend_off <= 1'b0; tx_hold <= 1'b0;
      rx_out_valid <= 1'b0; rx_out_byte <= '0; irq <= 1'b0;
    end else begin
      if (rmode != M_BOTH) begin
        pend_on <= 1'b0; pend_off <= 1'b0;
      end else if (rx_valid) begin
        pend_on <= nxt_pon; pend_off <= nxt_poff;
      end
      if (rmode == M_OFF) tx_hold <= 1'b0;
      else if (off_evt) tx_hold <= 1'b1;
      else if (on_evt || (cfg_any_resume && rx_valid)) tx_hold <= 1'b0;
      rx_out_valid <= rx_valid && !eat;
      if (rx_valid) rx_out_byte <= rx_byte;
      if (on_evt || off_evt) irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;
    end
  end

  assign irq_code = irq ? IRQ_CODE : 6'h00;

  logic tx_step, tx_kind;
  wire [CW-1:0] off_first = (tmode == M_P2) ? cfg_xoff2 : cfg_xoff1;
  wire [CW-1:0] on_first  = (tmode == M_P2) ? cfg_xon2  : cfg_xon1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ins_req <= 1'b0; ins_char <= '0; tx_step <= 1'b0; tx_kind <= 1'b0; xoff_sent <= 1'b0;
    end else if (tmode == M_OFF) begin
      ins_req <= 1'b0; tx_step <= 1'b0; xoff_sent <= 1'b0;
    end else if (ins_req) begin
      if (ins_ack) begin
        if (tmode == M_BOTH && !tx_step) begin
          tx_step  <= 1'b1;
          ins_char <= tx_kind ? cfg_xoff2 : cfg_xon2;
        end else begin
          ins_req   <= 1'b0;
          tx_step   <= 1'b0;
          xoff_sent <= tx_kind;
        end
      end
    end else if (rx_level > lvl_hi && !xoff_sent) begin
      ins_req <= 1'b1; tx_kind <= 1'b1; ins_char <= off_first;
    end else if (rx_level < lvl_lo && xoff_sent) begin
      ins_req <= 1'b1; tx_kind <= 1'b0; ins_char <= on_first;
    end
  end
endmodule

module xonxoff_flow_chk #(parameter int CW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    cfg_flow,
  input logic          rx_valid,
  input logic          rx_out_valid,
  input logic          tx_hold,
  input logic          ins_req,
  input logic [CW-1:0] ins_char,
  input logic          ins_ack,
  input logic          irq,
  input logic [5:0]    irq_code
);
  // R1
  hold_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_hold) |-> $past(rx_valid));
  // R4
  fwd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid |-> $past(rx_valid));
  // R6
  hold_off_when_rx_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flow[1:0] == 2'b00) |=> !tx_hold);
  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(rx_valid) && irq_code == 6'h10));
  // R10
  ins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req && !ins_ack && cfg_flow[3:2] != 2'b00) |=> (ins_req && $stable(ins_char)));
  // R11
  tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flow[3:2] == 2'b00) |=> !ins_req);
endmodule

bind xonxoff_flow_ctl xonxoff_flow_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_flow(cfg_flow), .rx_valid(rx_valid),
  .rx_out_valid(rx_out_valid), .tx_hold(tx_hold), .ins_req(ins_req),
  .ins_char(ins_char), .ins_ack(ins_ack), .irq(irq), .irq_code(irq_code)
);

// File: tb/xonxoff_flow_ctl_tb.sv
module xonxoff_flow_ctl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] cfg_xon1 = 8'h11, cfg_xoff1 = 8'h13, cfg_xon2 = 8'h91, cfg_xoff2 = 8'h93;
  logic [3:0] cfg_flow = 4'b0000;
  logic cfg_any_resume = 1'b0, rx_valid = 1'b0, ins_ack = 1'b0, irq_ack = 1'b0;
  logic [7:0] rx_byte = 8'h00, rx_level = 8'd128, lvl_hi = 8'd192, lvl_lo = 8'd64;
  logic rx_out_valid, tx_hold, ins_req, xoff_sent, irq;
  logic [7:0] rx_out_byte, ins_char;
  logic [5:0] irq_code;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  xonxoff_flow_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_xon1(cfg_xon1), .cfg_xoff1(cfg_xoff1),
    .cfg_xon2(cfg_xon2), .cfg_xoff2(cfg_xoff2), .cfg_flow(cfg_flow),
    .cfg_any_resume(cfg_any_resume), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_out_valid(rx_out_valid), .rx_out_byte(rx_out_byte), .tx_hold(tx_hold),
    .rx_level(rx_level), .lvl_hi(lvl_hi), .lvl_lo(lvl_lo), .ins_req(ins_req),
    .ins_char(ins_char), .ins_ack(ins_ack), .xoff_sent(xoff_sent), .irq(irq),
    .irq_code(irq_code), .irq_ack(irq_ack)
  );

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic ack_irq();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic ack_ins();
    @(negedge clk); ins_ack = 1'b1;
    @(negedge clk); ins_ack = 1'b0;
  endtask

  task automatic set_mode(logic [3:0] m);
    @(negedge clk); cfg_flow = m;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("reset tx_hold", tx_hold, 0);
    chk("reset ins_req", ins_req, 0);
    chk("reset irq R7", {irq, irq_code}, 0);
    chk("reset xoff_sent", xoff_sent, 0);
  endtask

  task automatic t_pair1();
    set_mode(4'b0010);
    send(8'h13);
    chk("R1 xoff1 holds", tx_hold, 1);
    chk("R4 xoff1 not forwarded", rx_out_valid, 0);
    chk("R7 irq set", irq, 1);
    chk("R7 irq code", irq_code, 6'h10);
    ack_irq();
    chk("R7 irq cleared", {irq, irq_code}, 0);
    send(8'h91);
    chk("R1 xon2 ignored", tx_hold, 1);
    chk("R4 xon2 forwarded", {rx_out_valid, rx_out_byte}, {1'b1, 8'h91});
    send(8'h11);
    chk("R1 xon1 releases", tx_hold, 0);
    ack_irq();
  endtask

  task automatic t_pair2();
    set_mode(4'b0001);
    send(8'h93);
    chk("R2 xoff2 holds", tx_hold, 1);
    send(8'h13);
    chk("R2 xoff1 forwarded", {rx_out_valid, rx_out_byte}, {1'b1, 8'h13});
    chk("R2 hold kept", tx_hold, 1);
    send(8'h91);
    chk("R2 xon2 releases", tx_hold, 0);
    ack_irq();
  endtask

  task automatic t_seq();
    set_mode(4'b0011);
    send(8'h13);
    chk("R3 first char no hold", tx_hold, 0);
    chk("R3 first char consumed", rx_out_valid, 0);
    chk("R7 no irq on first char", irq, 0);
    send(8'h93);
    chk("R3 pair holds", tx_hold, 1);
    chk("R3 second consumed", rx_out_valid, 0);
    send(8'h11);
    send(8'h55);
    chk("R3 mismatch forwarded", {rx_out_valid, rx_out_byte}, {1'b1, 8'h55});
    chk("R3 mismatch keeps hold", tx_hold, 1);
    send(8'h91);
    chk("R3 lone second forwarded", {rx_out_valid, rx_out_byte}, {1'b1, 8'h91});
    chk("R3 lone second no release", tx_hold, 1);
    send(8'h11);
    send(8'h91);
    chk("R3 pair releases", tx_hold, 0);
    ack_irq();
  endtask

  task automatic t_any();
    set_mode(4'b0010);
    cfg_any_resume = 1'b1;
    send(8'h13);
    chk("R5 hold set", tx_hold, 1);
    send(8'h41);
    chk("R5 any byte releases", tx_hold, 0);
    chk("R5 byte forwarded", {rx_out_valid, rx_out_byte}, {1'b1, 8'h41});
    cfg_any_resume = 1'b0;
    ack_irq();
  endtask

  task automatic t_rxoff();
    set_mode(4'b0010);
    send(8'h13);
    chk("R6 hold before", tx_hold, 1);
    set_mode(4'b0000);
    chk("R6 hold cleared", tx_hold, 0);
    send(8'h13);
    chk("R6 xoff forwarded", {rx_out_valid, rx_out_byte}, {1'b1, 8'h13});
    chk("R6 no hold", tx_hold, 0);
    ack_irq();
  endtask

  task automatic t_tx1();
    set_mode(4'b1000);
    @(negedge clk); rx_level = 8'd200;
    @(negedge clk);
    chk("R8 xoff request", {ins_req, ins_char}, {1'b1, 8'h13});
    repeat (3) @(negedge clk);
    chk("R10 request held", {ins_req, ins_char}, {1'b1, 8'h13});
    ack_ins();
    chk("R10 request done", ins_req, 0);
    chk("R10 xoff_sent set", xoff_sent, 1);
    repeat (2) @(negedge clk);
    chk("R8 no repeat", ins_req, 0);
    rx_level = 8'd10;
    @(negedge clk);
    chk("R9 xon request", {ins_req, ins_char}, {1'b1, 8'h11});
    ack_ins();
    chk("R10 xoff_sent cleared", {ins_req, xoff_sent}, 0);
    rx_level = 8'd128;
  endtask

  task automatic t_tx2();
    set_mode(4'b0100);
    @(negedge clk); rx_level = 8'd200;
    @(negedge clk);
    chk("R8 xoff2 request", {ins_req, ins_char}, {1'b1, 8'h93});
    ack_ins();
    @(negedge clk); rx_level = 8'd10;
    @(negedge clk);
    chk("R9 xon2 request", {ins_req, ins_char}, {1'b1, 8'h91});
    ack_ins();
    rx_level = 8'd128;
  endtask

  task automatic t_tx12();
    set_mode(4'b1100);
    @(negedge clk); rx_level = 8'd200;
    @(negedge clk);
    chk("R10 both first", {ins_req, ins_char}, {1'b1, 8'h13});
    ack_ins();
    chk("R10 both second", {ins_req, ins_char, xoff_sent}, {1'b1, 8'h93, 1'b0});
    ack_ins();
    chk("R10 both done", {ins_req, xoff_sent}, {1'b0, 1'b1});
    rx_level = 8'd10;
    @(negedge clk);
    chk("R9 both xon first", {ins_req, ins_char}, {1'b1, 8'h11});
    ack_ins();
    chk("R10 both xon second", {ins_req, ins_char}, {1'b1, 8'h91});
    ack_ins();
    chk("R10 both xon done", {ins_req, xoff_sent}, 0);
    rx_level = 8'd128;
  endtask

  task automatic t_txoff();
    set_mode(4'b1000);
    @(negedge clk); rx_level = 8'd200;
    @(negedge clk);
    ack_ins();
    chk("R11 sent before", xoff_sent, 1);
    set_mode(4'b0000);
    chk("R11 sent cleared", xoff_sent, 0);
    repeat (3) @(negedge clk);
    chk("R11 no request", ins_req, 0);
    set_mode(4'b1000);
    chk("R11 request pending", ins_req, 1);
    set_mode(4'b0000);
    chk("R11 pending dropped", ins_req, 0);
    rx_level = 8'd128;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pair1();
    t_pair2();
    t_seq();
    t_any();
    t_rxoff();
    t_tx1();
    t_tx2();
    t_tx12();
    t_txoff();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule